// File: doc/BRIEF.md
# Secured Configuration Store

This block holds the configuration vector that drives a programmable logic array and takes commands for it. It takes four commands: program a word, read a word back, erase the whole store, and set the security bit. Each command comes with one valid strobe and a two-bit opcode. The full vector is always driven on `cfg_o`, so the array keeps working in every state.

Programming is one-way. A program command ORs the data into the addressed word, so a cell can move from erased (0) to programmed (1) but never back. Only an erase returns cells to 0.

Once the security bit is set, the store protects its contents. Every readback returns all ones, as if every cell were programmed. Program commands are dropped and flagged with a one-cycle error pulse. The protection holds until a full erase, which clears all cells and the security bit in the same cycle. After that the store accepts a new configuration.

Top module: `cfg_store`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `cfg_o` is all zeros and `secured_o`, `rvalid_o` and `err_o` are low.
- R2: A program command (`cmd_op_i` = 2'b00) while unsecured ORs `wdata_i` into word `addr_i`. Word k occupies `cfg_o[k*WORD_W +: WORD_W]`. The new value is on `cfg_o` after the edge that samples the command.
- R3: A program command never clears a bit: bits at 0 in `wdata_i` leave the stored bit unchanged. Only erase lowers a bit.
- R4: A read command (2'b01) while unsecured drives the addressed word on `rdata_o` and holds `rvalid_o` high for exactly the one cycle after the sampling edge.
- R5: A secure command (2'b11) raises `secured_o` after its edge. `secured_o` then stays high until an erase.
- R6: A read command while secured returns all ones on `rdata_o`, with `rvalid_o` high and `err_o` low.
- R7: A program command while secured leaves `cfg_o` unchanged. It raises `err_o` for one cycle, after the sampling edge.
- R8: While secured, `cfg_o` keeps presenting the stored configuration unchanged.
- R9: An erase command (2'b10) clears every bit of `cfg_o` and `secured_o` after its edge.
- R10: After an erase, program commands are accepted again, and reads return true contents.
- R11: With `cmd_valid_i` low, no state or output changes, except that `rvalid_o` and `err_o` return low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Opcode: 00 program, 01 read, 10 erase, 11 secure |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | WORD_W | Program data, 1 = program cell |
| rdata_o | output | WORD_W | Readback data |
| rvalid_o | output | 1 | Readback valid, one cycle |
| err_o | output | 1 | Rejected program pulse |
| secured_o | output | 1 | Security bit state |
| cfg_o | output | 2**ADDR_W*WORD_W | Configuration vector to the logic array |

## Verification
Every result is due one cycle after the edge that samples the command. This covers the `cfg_o` update, the `rdata_o`/`rvalid_o` pair, the `err_o` pulse, and the change of `secured_o`. The bench drives each command on a falling edge and removes it on the next falling edge. It samples all outputs at that moment, which falls between the capturing edge and the following one. One-cycle pulses are then sampled once more, a further falling edge later, to show they have dropped.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'b00,
    OP_READ   = 2'b01,
    OP_ERASE  = 2'b10,
    OP_SECURE = 2'b11
  } op_e;

  typedef struct packed {
    logic prog;
    logic read;
    logic erase;
    logic secure;
    logic reject;
  } strobe_t;
endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
  import cfg_store_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] op_i,
  input  logic       secured_i,
  output strobe_t    strb_o
);
  op_e op;
  assign op = op_e'(op_i);

  always_comb begin
    strb_o = '0;
    if (valid_i) begin
      unique case (op)
        OP_PROG: begin
          strb_o.prog   = !secured_i;
          strb_o.reject = secured_i;
        end
        OP_READ:   strb_o.read   = 1'b1;
        OP_ERASE:  strb_o.erase  = 1'b1;
        OP_SECURE: strb_o.secure = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_cell_array.sv
module cfg_cell_array #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int CFG_W = DEPTH * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [CFG_W-1:0]  cfg_o
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              sel;
    assign sel = prog_i && (addr_i == ADDR_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      word_q <= '0;
      else if (erase_i) word_q <= '0;
      else if (sel)     word_q <= word_q | wdata_i;  // one-way programming
    end

    assign cfg_o[k*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int CFG_W = DEPTH * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              secured_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [WORD_W-1:0] words [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_view
    assign words[k] = cfg_i[k*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= secured_i ? '1 : words[addr_i];
    end
  end
endmodule

// File: rtl/cfg_security.sv
module cfg_security (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic reject_i,
  output logic secured_o,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      secured_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      err_o <= reject_i;
      if (clr_i)      secured_o <= 1'b0;
      else if (set_i) secured_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_store_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int CFG_W = DEPTH * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              err_o,
  output logic              secured_o,
  output logic [CFG_W-1:0]  cfg_o
);
  strobe_t strb;

  cfg_cmd_decode u_dec (
    .valid_i   (cmd_valid_i),
    .op_i      (cmd_op_i),
    .secured_i (secured_o),
    .strb_o    (strb)
  );

  cfg_cell_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_cells (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .prog_i  (strb.prog),
    .erase_i (strb.erase),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cfg_o   (cfg_o)
  );

  cfg_read_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (strb.read),
    .secured_i (secured_o),
    .addr_i    (addr_i),
    .cfg_i     (cfg_o),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  cfg_security u_sec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (strb.secure),
    .clr_i     (strb.erase),
    .reject_i  (strb.reject),
    .secured_o (secured_o),
    .err_o     (err_o)
  );
endmodule

// File: rtl/cfg_store_checker.sv
module cfg_store_checker #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int CFG_W = DEPTH * WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_op_i,
  input logic [WORD_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic              err_o,
  input logic              secured_o,
  input logic [CFG_W-1:0]  cfg_o
);
  logic is_prog, is_read, is_erase;
  assign is_prog  = cmd_valid_i && (cmd_op_i == 2'b00);
  assign is_read  = cmd_valid_i && (cmd_op_i == 2'b01);
  assign is_erase = cmd_valid_i && (cmd_op_i == 2'b10);

  a_r3_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_erase |=> ((cfg_o & $past(cfg_o)) == $past(cfg_o)));

  a_r4_rvalid_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(is_read));

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (secured_o && !is_erase) |=> secured_o);

  a_r6_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && secured_o) |-> (rdata_o == '1));

  a_r7_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(is_prog && secured_o));

  a_r7_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_prog && secured_o) |=> $stable(cfg_o));

  a_r9_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_erase |=> (cfg_o == '0 && !secured_o));
endmodule

bind cfg_store cfg_store_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .rdata_o     (rdata_o),
  .rvalid_o    (rvalid_o),
  .err_o       (err_o),
  .secured_o   (secured_o),
  .cfg_o       (cfg_o)
);

// File: tb/cfg_store_test.sv
module cfg_store_test;
  localparam int ADDR_W = 4;
  localparam int WORD_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CFG_W  = DEPTH * WORD_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_valid_i = 1'b0;
  logic [1:0]        cmd_op_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [WORD_W-1:0] wdata_i = '0;
  logic [WORD_W-1:0] rdata_o;
  logic              rvalid_o, err_o, secured_o;
  logic [CFG_W-1:0]  cfg_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [CFG_W-1:0] exp_cfg = '0;

  always #2.5 clk = ~clk;

  cfg_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .err_o(err_o), .secured_o(secured_o), .cfg_o(cfg_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [CFG_W-1:0] act,
                     input logic [CFG_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on a falling edge, return one falling edge later (results are due then)
  task automatic issue(input logic [1:0] op, input int a, input logic [WORD_W-1:0] d);
    cmd_valid_i = 1'b1; cmd_op_i = op; addr_i = ADDR_W'(a); wdata_i = d;
    @(negedge clk);
    cmd_valid_i = 1'b0; wdata_i = '0;
  endtask

  function automatic logic [WORD_W-1:0] pat(input int k, input int salt);
    return WORD_W'(k * 37 + salt);
  endfunction

  task automatic t_reset();
    chk(cfg_o == '0, "R1 cfg", cfg_o, '0);
    chk(!secured_o && !rvalid_o && !err_o, "R1 flags",
        CFG_W'({secured_o, rvalid_o, err_o}), '0);
  endtask

  task automatic t_program(input int salt);
    for (int k = 0; k < DEPTH; k++) begin
      issue(2'b00, k, pat(k, salt));
      exp_cfg[k*WORD_W +: WORD_W] = exp_cfg[k*WORD_W +: WORD_W] | pat(k, salt);
      chk(!err_o, "R2 no err", CFG_W'(err_o), '0);
    end
    chk(cfg_o == exp_cfg, "R2 cfg", cfg_o, exp_cfg);
  endtask

  task automatic t_no_clear();
    issue(2'b00, 3, 8'h00);
    chk(cfg_o == exp_cfg, "R3 zero data", cfg_o, exp_cfg);
    issue(2'b00, 5, 8'h0F);
    exp_cfg[5*WORD_W +: WORD_W] = exp_cfg[5*WORD_W +: WORD_W] | 8'h0F;
    chk(cfg_o == exp_cfg, "R3 or only", cfg_o, exp_cfg);
  endtask

  task automatic t_readback(input string tag);
    for (int k = 0; k < DEPTH; k += 5) begin
      issue(2'b01, k, '0);
      chk(rvalid_o && rdata_o == exp_cfg[k*WORD_W +: WORD_W], tag,
          CFG_W'({rvalid_o, rdata_o}), CFG_W'({1'b1, exp_cfg[k*WORD_W +: WORD_W]}));
      @(negedge clk);
      chk(!rvalid_o, "R4 pulse", CFG_W'(rvalid_o), '0);
    end
  endtask

  task automatic t_idle();
    cmd_op_i = 2'b10; wdata_i = '1;
    repeat (3) @(negedge clk);
    chk(cfg_o == exp_cfg && !rvalid_o && !err_o, "R11 idle", cfg_o, exp_cfg);
    wdata_i = '0;
  endtask

  task automatic t_secure();
    issue(2'b11, 0, '0);
    chk(secured_o, "R5 set", CFG_W'(secured_o), 1);
    chk(cfg_o == exp_cfg, "R8 cfg live", cfg_o, exp_cfg);
    repeat (4) @(negedge clk);
    chk(secured_o, "R5 hold", CFG_W'(secured_o), 1);
    issue(2'b01, 2, '0);
    chk(rvalid_o && rdata_o == '1 && !err_o, "R6 masked",
        CFG_W'({rvalid_o, err_o, rdata_o}), CFG_W'({2'b10, {WORD_W{1'b1}}}));
    issue(2'b00, 7, 8'hFF);
    chk(err_o, "R7 err", CFG_W'(err_o), 1);
    chk(cfg_o == exp_cfg, "R7 ignored", cfg_o, exp_cfg);
    @(negedge clk);
    chk(!err_o, "R7 one cycle", CFG_W'(err_o), '0);
    issue(2'b11, 0, '0);
    chk(secured_o && cfg_o == exp_cfg, "R8 still", cfg_o, exp_cfg);
  endtask

  task automatic t_erase();
    issue(2'b10, 0, '0);
    exp_cfg = '0;
    chk(cfg_o == '0, "R9 cfg clear", cfg_o, '0);
    chk(!secured_o, "R9 unsecure", CFG_W'(secured_o), '0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_program(5);
    t_no_clear();
    t_readback("R4 read");
    t_idle();
    t_secure();
    t_erase();
    t_program(91);
    chk(!secured_o, "R10 open", CFG_W'(secured_o), '0);
    t_readback("R10 read");
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule